// File: doc/BRIEF.md
# Dual-Direction Latched/Registered Bus Transceiver

This block moves a data word between two ports, side A and side B, in both directions at once. Each direction owns a storage element and three controls: a level-sensitive latch enable, a direction clock and an output enable. While the latch enable is high the destination side shows the source side directly, with no clock involved. While it is low the destination side shows a stored word. That word is reloaded only on a falling transition of the direction clock. When the direction clock holds steady, the word stays as it is.

The A-to-B output enable is active high and the B-to-A output enable is active low. Each output is modelled as a data word plus a drive flag; tristate pads are not used. Storage runs on a single system clock. The direction clocks are sampled by that clock, and a falling transition is detected from the previous sampled level. Every bit channel is identical, and all channels in one direction share that direction's controls. The data path never inverts.

Top module: `bidir_hold_xcvr`

## Requirements
- R1: While a direction's latch enable is high (after reset), its destination output equals its source input in the same cycle, whatever its direction clock does.
- R2: While a latch enable is low, a falling transition of that direction's clock loads the stored word. The transition is seen as level 1 at one system clock edge and level 0 at the next, and the word loaded is the source value sampled at that second edge. The output shows the loaded word from the cycle after that edge.
- R3: While a latch enable is low and its direction clock does not fall (steady high, steady low, or rising), the output keeps showing the stored word unchanged, whatever the source input does.
- R4: When a latch enable goes from high to low, the stored word is the source value sampled at the last system clock edge at which the enable was still high.
- R5: The A-to-B drive flag is 1 exactly when the A-to-B output enable is 1 and reset is released.
- R6: The B-to-A drive flag is 1 exactly when the B-to-A output enable is 0 and reset is released (active-low enable).
- R7: The two directions share no storage or control. Both may be enabled and operate in different modes at the same time without affecting each other.
- R8: Output enables only gate the drive flags and never change stored words. When an output is enabled again, it shows the same stored word it had before it was disabled.
- R9: While reset is low, both drive flags are 0 and both stored words are cleared. After reset, a direction whose latch enable is low shows an all-zero word until its first load.
- R10: The path is non-inverting, bit for bit, over a configurable width WIDTH (default 18). Every bit position carries its own source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; storage and clock sampling happen on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| aIn | input | WIDTH | Side A word as seen on the bus, source for A-to-B |
| bIn | input | WIDTH | Side B word as seen on the bus, source for B-to-A |
| abLatchEn | input | 1 | A-to-B latch enable, high = transparent |
| abClk | input | 1 | A-to-B direction clock, falling transition loads |
| abOutEn | input | 1 | A-to-B output enable, active high |
| baLatchEn | input | 1 | B-to-A latch enable, high = transparent |
| baClk | input | 1 | B-to-A direction clock, falling transition loads |
| baOutEnN | input | 1 | B-to-A output enable, active low |
| bOut | output | WIDTH | Word presented on side B |
| bDrive | output | 1 | Side B is driven when 1 |
| aOut | output | WIDTH | Word presented on side A |
| aDrive | output | 1 | Side A is driven when 1 |

## Verification
The bench builds the block at its default width of 18. This is wide enough to show that each bit position carries its own bit, using all-ones, all-zeros and alternating patterns, and that no channel is mixed with another. A behavioural model, one pair of variables per direction, is compared against all four outputs on every cycle. Directed steps force the transparent, falling-clock, held, enable-drop and disabled cases, and run one direction transparent while the other captures. A long randomised stretch then mixes the enables, clocks and data in both directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes from one direction's control slice to its datapath slice
  typedef struct packed {
    logic track;     // load the source word every cycle (latch open)
    logic capture;   // load the source word on a detected falling clock
    logic showLive;  // route the source word straight to the output
    logic drive;     // destination side is driven
  } dirStrobe_t;

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
#(
  parameter bit OE_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchEn,
  input  logic       dirClk,
  input  logic       outEnRaw,
  output dirStrobe_t strb
);

  logic prevClk;
  logic outEnOn;
  logic fallSeen;

  // previous sampled level of the direction clock
  always_ff @(posedge clk) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= dirClk;
  end

  assign fallSeen = prevClk & ~dirClk;

  // polarity of the output enable picked per direction
  generate
    if (OE_ACTIVE_HIGH) begin : g_oeHigh
      assign outEnOn = outEnRaw;
    end else begin : g_oeLow
      assign outEnOn = ~outEnRaw;
    end
  endgenerate

  always_comb begin
    strb          = '0;
    strb.track    = latchEn;
    strb.capture  = ~latchEn & fallSeen;
    strb.showLive = latchEn;
    strb.drive    = rstN & outEnOn;
  end

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] inData,
  input  dirStrobe_t       strb,
  output logic [WIDTH-1:0] outData,
  output logic             outDrive
);

  logic [WIDTH-1:0] stored;

  always_ff @(posedge clk) begin
    if (!rstN)                          stored <= '0;
    else if (strb.track | strb.capture) stored <= inData;
  end

  assign outData  = strb.showLive ? inData : stored;
  assign outDrive = strb.drive;

  // R2: a detected falling edge loads the source word seen at that edge
  a_r2_capture_loads: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (stored == $past(inData)));

  // R9: storage is all zero on the first cycle out of reset
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (stored == '0));

endmodule

// File: rtl/bidir_hold_xcvr.sv
module bidir_hold_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             abLatchEn,
  input  logic             abClk,
  input  logic             abOutEn,
  input  logic             baLatchEn,
  input  logic             baClk,
  input  logic             baOutEnN,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive
);

  localparam int NUM_DIR = 2;  // index 0: A-to-B, index 1: B-to-A

  logic [NUM_DIR-1:0][WIDTH-1:0] srcData;
  logic [NUM_DIR-1:0][WIDTH-1:0] dstData;
  logic [NUM_DIR-1:0]            dstDrive;
  logic [NUM_DIR-1:0]            leVec;
  logic [NUM_DIR-1:0]            clkVec;
  logic [NUM_DIR-1:0]            oeVec;
  dirStrobe_t [NUM_DIR-1:0]      strbVec;

  assign srcData[0] = aIn;
  assign srcData[1] = bIn;
  assign leVec      = {baLatchEn, abLatchEn};
  assign clkVec     = {baClk, abClk};
  assign oeVec      = {baOutEnN, abOutEn};

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      xcvr_dir_ctrl #(
        .OE_ACTIVE_HIGH(d == 0)
      ) u_ctrl (
        .clk     (clk),
        .rstN    (rstN),
        .latchEn (leVec[d]),
        .dirClk  (clkVec[d]),
        .outEnRaw(oeVec[d]),
        .strb    (strbVec[d])
      );

      xcvr_dir_path #(
        .WIDTH(WIDTH)
      ) u_path (
        .clk     (clk),
        .rstN    (rstN),
        .inData  (srcData[d]),
        .strb    (strbVec[d]),
        .outData (dstData[d]),
        .outDrive(dstDrive[d])
      );
    end
  endgenerate

  assign bOut   = dstData[0];
  assign bDrive = dstDrive[0];
  assign aOut   = dstData[1];
  assign aDrive = dstDrive[1];

  // R1: open latch passes the source straight through
  a_r1_ab_transparent: assert property (@(posedge clk) disable iff (!rstN)
    abLatchEn |-> (bOut == aIn));

  // R3: closed latch with a steady-high clock keeps the output word
  a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!abLatchEn && abClk) |=> (abLatchEn || !abClk || $stable(bOut)));

  // R5: A-to-B enable low means side B is not driven
  a_r5_ab_off: assert property (@(posedge clk) disable iff (!rstN)
    !abOutEn |-> !bDrive);

  // R6: B-to-A enable high (inactive) means side A is not driven
  a_r6_ba_off: assert property (@(posedge clk) disable iff (!rstN)
    baOutEnN |-> !aDrive);

endmodule

// File: tb/bidir_hold_xcvr_tb.sv
module bidir_hold_xcvr_tb;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] aIn, bIn;
  logic         abLatchEn, abClk, abOutEn;
  logic         baLatchEn, baClk, baOutEnN;
  logic [W-1:0] bOut, aOut;
  logic         bDrive, aDrive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string curReq = "R9";

  always #5 clk = ~clk;

  bidir_hold_xcvr #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .abLatchEn(abLatchEn), .abClk(abClk), .abOutEn(abOutEn),
    .baLatchEn(baLatchEn), .baClk(baClk), .baOutEnN(baOutEnN),
    .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive)
  );

  // behavioural reference: one stored word and one last clock level per direction
  logic [W-1:0] mStore [2];
  bit           mLast  [2];

  always @(posedge clk) begin
    if (rstN !== 1'b1) begin
      mStore[0] = '0; mStore[1] = '0; mLast[0] = 0; mLast[1] = 0;
    end else begin
      if (abLatchEn) mStore[0] = aIn;
      else if (mLast[0] && !abClk) mStore[0] = aIn;
      if (baLatchEn) mStore[1] = bIn;
      else if (mLast[1] && !baClk) mStore[1] = bIn;
      mLast[0] = abClk;
      mLast[1] = baClk;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [W-1:0] eB, eA;
      logic dB, dA;
      eB = abLatchEn ? aIn : mStore[0];
      eA = baLatchEn ? bIn : mStore[1];
      dB = (rstN === 1'b1) && abOutEn;
      dA = (rstN === 1'b1) && !baOutEnN;
      if (rstN === 1'b1) begin
        chk(curReq, bOut, eB, "bOut model");
        chk(curReq, aOut, eA, "aOut model");
      end
      chk(curReq, {{(W-1){1'b0}}, bDrive}, {{(W-1){1'b0}}, dB}, "bDrive model");
      chk(curReq, {{(W-1){1'b0}}, aDrive}, {{(W-1){1'b0}}, dA}, "aDrive model");
    end
  end

  task automatic go();
    @(posedge clk); #2;
  endtask

  task automatic atSample();
    @(negedge clk); #1;
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    logic [W-1:0] pX, pY, pP;
    rstN = 0; aIn = '1; bIn = '1;
    abLatchEn = 0; abClk = 0; abOutEn = 1;
    baLatchEn = 0; baClk = 0; baOutEnN = 0;
    repeat (3) go();
    atSample();
    // R9: drives forced off in reset although both enables are active
    chk("R9", {{(W-1){1'b0}}, bDrive}, '0, "bDrive in reset");
    chk("R9", {{(W-1){1'b0}}, aDrive}, '0, "aDrive in reset");
    go();
    rstN = 1; aIn = 18'h2AAAA; bIn = 18'h15555;
    go();
    atSample();
    chk("R9", bOut, '0, "bOut cleared after reset");
    chk("R9", aOut, '0, "aOut cleared after reset");

    // R1 and R10: transparent with distinct patterns, clock toggling
    curReq = "R1";
    abLatchEn = 1;
    foreach (pX[i]) pX[i] = i[0];
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] pat;
      pat = (k == 0) ? '1 : (k == 1) ? '0 : (k == 2) ? pX : ~pX;
      aIn = pat; abClk = k[0];
      atSample();
      chk("R10", bOut, pat, "bit-for-bit non-inverting pass");
      go();
    end

    // R4: value held when the latch enable falls
    curReq = "R4";
    pX = 18'h1F0E1; pY = 18'h0ABCD;
    aIn = pX; abLatchEn = 1; abClk = 1;
    go();
    aIn = pY; abLatchEn = 0;
    atSample();
    chk("R4", bOut, pX, "value at enable drop");
    go();

    // R2: falling direction clock loads
    curReq = "R2";
    pP = 18'h3C3C3;
    abClk = 1; go();
    aIn = pP; abClk = 0; go();
    aIn = 18'h00011;
    atSample();
    chk("R2", bOut, pP, "captured on falling clock");

    // R3: steady low, then rising: no load
    curReq = "R3";
    for (int k = 0; k < 3; k++) begin aIn = 18'h11111 * (k + 1); go(); end
    abClk = 1; aIn = 18'h0F0F0; go(); go();
    atSample();
    chk("R3", bOut, pP, "held through steady and rising clock");

    // R5 and R8: disable then enable, storage untouched
    curReq = "R5";
    abOutEn = 0; go();
    atSample();
    chk("R5", {{(W-1){1'b0}}, bDrive}, '0, "bDrive off when enable low");
    abOutEn = 1; curReq = "R8"; go();
    atSample();
    chk("R8", bOut, pP, "same word after re-enable");
    chk("R5", {{(W-1){1'b0}}, bDrive}, 1, "bDrive on when enable high");

    // R6: active-low enable on B-to-A
    curReq = "R6";
    baOutEnN = 1; go();
    atSample();
    chk("R6", {{(W-1){1'b0}}, aDrive}, '0, "aDrive off when enable high");
    baOutEnN = 0; go();
    atSample();
    chk("R6", {{(W-1){1'b0}}, aDrive}, 1, "aDrive on when enable low");

    // R7: A-to-B transparent while B-to-A captures, both enabled
    curReq = "R7";
    abLatchEn = 1; baLatchEn = 0; baClk = 1; aIn = 18'h12345; go();
    bIn = 18'h2FEDC; baClk = 0; aIn = 18'h3ACE1; go();
    bIn = 18'h00000;
    atSample();
    chk("R7", aOut, 18'h2FEDC, "B-to-A capture while A-to-B open");
    chk("R7", bOut, aIn, "A-to-B open while B-to-A captures");

    // mixed stretch: model compared every cycle
    curReq = "R7";
    for (int k = 0; k < 600; k++) begin
      aIn = W'($urandom); bIn = W'($urandom);
      abLatchEn = ($urandom % 4) == 0; baLatchEn = ($urandom % 4) == 0;
      abClk = $urandom; baClk = $urandom;
      abOutEn = $urandom; baOutEnN = $urandom;
      go();
    end
    atSample();
    finishUp();
  end

endmodule